// File: doc/BRIEF.md
# SPI ADC Register Access Engine

This block reads and writes the registers of an external converter through an SPI link, and brings the converter up with a fixed configuration sequence. The link uses mode 0 with the most significant bit first. A request gives an operation code, a 4-bit register index and a data byte. The engine then runs every chip-select frame the operation needs and returns a one-cycle done pulse. After a read, the result is on `rd_data`. A failed write raises `err`.

Every write is checked. The engine sends the write frame, reads the same register back in a separate frame, and repeats the write until the two values agree. After `MAX_TRIES` attempts without a match it gives up and reports an error. The configuration operation first drops the converter's START line and resets the converter. It then writes the parameter-supplied values to the configuration registers, passing over the one register index that is skipped. The last value that was verified in the channel-sequence register is kept, so that a scan-restart operation can rewrite that register and raise START again.

Bit-level clocking is done by a byte shifter with a start/done handshake. A parameter can reverse each byte inside the block for converters that use the other bit order.

Top module: `adc_regio_engine`

## Requirements
- R1: A read (req_op=0) runs one frame: chip select goes low, command byte {3'b010, 1'b0, index[3:0]} goes out, one byte is clocked in while 8'h00 is sent, and chip select goes high. The received byte appears on rd_data when done pulses.
- R2: SCLK idles low and is high only while chip select is low. MOSI carries bits most significant first and changes only while SCLK is low. MISO is sampled on the rising SCLK edge.
- R3: A write (req_op=1) sends {3'b011, 1'b0, index} and then the data byte in one frame. It releases chip select and then reads the same register back as in R1. rd_data shows the readback.
- R4: If the readback differs from the written byte, the whole write-and-readback pair is repeated.
- R5: After MAX_TRIES (15) attempts without a match, the job ends with err=1 at the same time as done. err clears when the next request is accepted.
- R6: A configuration (req_op=2) drives adc_start low first. It then sends the single byte 8'hC0 in a frame of its own. adc_start stays low for the whole job.
- R7: The configuration then writes, with verification, registers 0, 1, 3, 4, 5 and 6 in that order. Register 2 is skipped. The value for the i-th write is CFG_VALUES[8*i+:8].
- R8: Each verified write to register 4, made by any operation, updates seq_value.
- R9: A scan restart (req_op=3) drops adc_start, writes seq_value to register 4 with verification, and raises adc_start only if that write is verified.
- R10: busy is high from the cycle after a request is accepted until done. done is a one-cycle pulse that coincides with busy going low. Reset leaves busy, done, err, adc_start and SCLK low and chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 2 | 0 read, 1 write, 2 configure, 3 scan restart |
| req_addr | input | 4 | Register index |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job completion pulse |
| err | output | 1 | Last write job exhausted its attempts |
| rd_data | output | 8 | Last byte read from the converter |
| seq_value | output | 8 | Retained channel-sequence value |
| spi_cs_n | output | 1 | Converter chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| adc_start | output | 1 | Converter START line |

## Verification
The assertions check the following on every cycle. SCLK pulses only while chip select is low. The shifter is never restarted in the middle of a byte. done is always a single-cycle pulse. err can only rise together with done. START stays low during a configuration and rises only when a scan restart succeeds. The attempt counter never reaches its limit. Other behaviour can only be shown by the bench's scenarios, which use a converter model that corrupts a chosen number of writes. These scenarios cover the exact frame contents and their order, the configuration's skipped register, the number of retries before success or error, the retained channel-sequence value, and the data returned by reads.

// File: rtl/adc_regio_pkg.sv
package adc_regio_pkg;
   typedef enum logic [1:0] {
      OP_READ   = 2'd0,
      OP_WRITE  = 2'd1,
      OP_CONFIG = 2'd2,
      OP_SCAN   = 2'd3
   } op_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_RST_BYTE, ST_WR_CMD, ST_WR_DAT,
      ST_RB_CMD, ST_RB_DAT, ST_GAP, ST_CHECK
   } st_e;

   localparam logic [2:0] PFX_READ  = 3'b010;
   localparam logic [2:0] PFX_WRITE = 3'b011;
   localparam logic [7:0] BYTE_RESET = 8'hC0;

   function automatic logic [7:0] flip8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction
endpackage

// File: rtl/adc_spi_shifter.sv
module adc_spi_shifter #(
   parameter int HALF_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   output logic       done,
   output logic [7:0] rx_byte,
   output logic       sclk,
   output logic       mosi,
   input  logic       miso
);
   localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

   logic             active_q, sclk_q, done_q;
   logic [7:0]       tx_q, rx_q;
   logic [2:0]       bit_q;
   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sclk_q   <= 1'b0;
         done_q   <= 1'b0;
         tx_q     <= '0;
         rx_q     <= '0;
         bit_q    <= '0;
         div_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            active_q <= 1'b1;
            tx_q     <= tx_byte;
            bit_q    <= '0;
            div_q    <= '0;
            sclk_q   <= 1'b0;
         end else if (active_q) begin
            if (div_q == DIV_LAST) begin
               div_q <= '0;
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
                  rx_q   <= {rx_q[6:0], miso};
               end else begin
                  sclk_q <= 1'b0;
                  if (bit_q == 3'd7) begin
                     active_q <= 1'b0;
                     done_q   <= 1'b1;
                  end else begin
                     bit_q <= bit_q + 3'd1;
                     tx_q  <= {tx_q[6:0], 1'b0};
                  end
               end
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
      end
   end

   assign done    = done_q;
   assign rx_byte = rx_q;
   assign sclk    = sclk_q;
   assign mosi    = tx_q[7];

   assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !active_q)
      else $error("shifter restarted mid-byte");
endmodule

// File: rtl/adc_regio_seq.sv
module adc_regio_seq
   import adc_regio_pkg::*;
#(
   parameter int          CFG_COUNT  = 6,
   parameter int          SKIP_REG   = 2,
   parameter int          SEQ_REG    = 4,
   parameter int          MAX_TRIES  = 15,
   parameter logic [47:0] CFG_VALUES = 48'h0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_op,
   input  logic [3:0] req_addr,
   input  logic [7:0] req_wdata,
   output logic       sh_start,
   output logic [7:0] sh_tx,
   input  logic       sh_done,
   input  logic [7:0] sh_rx,
   output logic       cs_n,
   output logic       adc_start,
   output logic       busy,
   output logic       done,
   output logic       err,
   output logic [7:0] rd_data,
   output logic [7:0] seq_value
);
   localparam int IDX_W = (CFG_COUNT > 1) ? $clog2(CFG_COUNT) : 1;
   localparam int TRY_W = $clog2(MAX_TRIES + 1);
   localparam logic [3:0]       SEQ_A    = 4'(SEQ_REG);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CFG_COUNT - 1);
   localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES - 1);

   function automatic logic [3:0] cfg_addr(input logic [IDX_W-1:0] i);
      int v;
      v = int'(i);
      if (v >= SKIP_REG) v = v + 1;
      return 4'(v);
   endfunction

   function automatic logic [7:0] cfg_val(input logic [IDX_W-1:0] i);
      return CFG_VALUES[8*int'(i) +: 8];
   endfunction

   st_e              st_q, ret_q;
   op_e              job_q;
   logic [3:0]       addr_q;
   logic [7:0]       wdata_q, rdata_q, seq_q, tx_q, tx_pick;
   logic [IDX_W-1:0] idx_q, idx_nxt;
   logic [TRY_W-1:0] tries_q;
   logic             launched_q, start_q, cs_q, done_q, err_q, go_q;

   assign idx_nxt = idx_q + 1'b1;

   always_comb begin
      case (st_q)
         ST_RST_BYTE: tx_pick = BYTE_RESET;
         ST_WR_CMD:   tx_pick = {PFX_WRITE, 1'b0, addr_q};
         ST_WR_DAT:   tx_pick = wdata_q;
         ST_RB_CMD:   tx_pick = {PFX_READ, 1'b0, addr_q};
         default:     tx_pick = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;   ret_q <= ST_IDLE;  job_q <= OP_READ;
         addr_q <= '0;      wdata_q <= '0;     rdata_q <= '0;
         seq_q <= '0;       tx_q <= '0;        idx_q <= '0;
         tries_q <= '0;     launched_q <= 1'b0; start_q <= 1'b0;
         cs_q <= 1'b1;      done_q <= 1'b0;    err_q <= 1'b0;
         go_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         go_q   <= 1'b0;
         case (st_q)
            ST_IDLE: if (req_valid) begin
               job_q   <= op_e'(req_op);
               err_q   <= 1'b0;
               tries_q <= '0;
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
               case (op_e'(req_op))
                  OP_READ:  st_q <= ST_RB_CMD;
                  OP_WRITE: st_q <= ST_WR_CMD;
                  OP_CONFIG: begin
                     start_q <= 1'b0;
                     idx_q   <= '0;
                     st_q    <= ST_RST_BYTE;
                  end
                  default: begin
                     start_q <= 1'b0;
                     addr_q  <= SEQ_A;
                     wdata_q <= seq_q;
                     st_q    <= ST_WR_CMD;
                  end
               endcase
            end
            ST_GAP: st_q <= ret_q;
            ST_CHECK: begin
               if (job_q == OP_READ) begin
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else if (rdata_q == wdata_q) begin
                  if (addr_q == SEQ_A) seq_q <= wdata_q;
                  if (job_q == OP_CONFIG && idx_q != IDX_LAST) begin
                     idx_q   <= idx_nxt;
                     addr_q  <= cfg_addr(idx_nxt);
                     wdata_q <= cfg_val(idx_nxt);
                     tries_q <= '0;
                     st_q    <= ST_WR_CMD;
                  end else begin
                     if (job_q == OP_SCAN) start_q <= 1'b1;
                     done_q <= 1'b1;
                     st_q   <= ST_IDLE;
                  end
               end else if (tries_q == TRY_LAST) begin
                  err_q  <= 1'b1;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else begin
                  tries_q <= tries_q + 1'b1;
                  st_q    <= ST_WR_CMD;
               end
            end
            default: begin
               if (!launched_q) begin
                  go_q       <= 1'b1;
                  launched_q <= 1'b1;
                  cs_q       <= 1'b0;
                  tx_q       <= tx_pick;
               end else if (sh_done) begin
                  launched_q <= 1'b0;
                  case (st_q)
                     ST_RST_BYTE: begin
                        cs_q <= 1'b1;  st_q <= ST_GAP;  ret_q <= ST_WR_CMD;
                        addr_q  <= cfg_addr('0);
                        wdata_q <= cfg_val('0);
                     end
                     ST_WR_CMD: st_q <= ST_WR_DAT;
                     ST_WR_DAT: begin
                        cs_q <= 1'b1;  st_q <= ST_GAP;  ret_q <= ST_RB_CMD;
                     end
                     ST_RB_CMD: st_q <= ST_RB_DAT;
                     default: begin
                        cs_q <= 1'b1;  rdata_q <= sh_rx;
                        st_q <= ST_GAP;  ret_q <= ST_CHECK;
                     end
                  endcase
               end
            end
         endcase
      end
   end

   assign sh_start  = go_q;
   assign sh_tx     = tx_q;
   assign cs_n      = cs_q;
   assign adc_start = start_q;
   assign busy      = (st_q != ST_IDLE);
   assign done      = done_q;
   assign err       = err_q;
   assign rd_data   = rdata_q;
   assign seq_value = seq_q;

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q) else $error("done longer than one cycle");
   assert_err_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> done_q) else $error("err rose without done");
   assert_tries_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q < TRY_W'(MAX_TRIES)) else $error("attempt count overran");
   assert_start_low_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && job_q == OP_CONFIG) |-> !start_q)
      else $error("START high during configuration");
   assert_start_rise_scan_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_q) |-> (done_q && job_q == OP_SCAN && !err_q))
      else $error("START rose outside a successful scan restart");
endmodule

// File: rtl/adc_regio_engine.sv
module adc_regio_engine
   import adc_regio_pkg::*;
#(
   parameter int          HALF_CYC   = 2,
   parameter bit          LSB_FIRST  = 1'b0,
   parameter int          CFG_COUNT  = 6,
   parameter int          SKIP_REG   = 2,
   parameter int          SEQ_REG    = 4,
   parameter int          MAX_TRIES  = 15,
   parameter logic [47:0] CFG_VALUES = 48'h00_00_00_00_00_00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_op,
   input  logic [3:0] req_addr,
   input  logic [7:0] req_wdata,
   output logic       busy,
   output logic       done,
   output logic       err,
   output logic [7:0] rd_data,
   output logic [7:0] seq_value,
   output logic       spi_cs_n,
   output logic       spi_sclk,
   output logic       spi_mosi,
   input  logic       spi_miso,
   output logic       adc_start
);
   if (HALF_CYC < 1) begin : g_bad_div
      $error("HALF_CYC must be at least 1");
   end
   if (MAX_TRIES < 1 || MAX_TRIES > 255) begin : g_bad_tries
      $error("MAX_TRIES out of range");
   end
   if (CFG_COUNT < 1 || CFG_COUNT > 6 || SKIP_REG > CFG_COUNT) begin : g_bad_cfg
      $error("configuration list shape out of range");
   end
   if (SEQ_REG < 0 || SEQ_REG > 15) begin : g_bad_seq
      $error("SEQ_REG must be a 4-bit index");
   end

   logic       sh_start, sh_done;
   logic [7:0] seq_tx, seq_rx, wire_tx, wire_rx;

   if (LSB_FIRST) begin : g_flip
      assign wire_tx = flip8(seq_tx);
      assign seq_rx  = flip8(wire_rx);
   end else begin : g_direct
      assign wire_tx = seq_tx;
      assign seq_rx  = wire_rx;
   end

   adc_regio_seq #(
      .CFG_COUNT(CFG_COUNT), .SKIP_REG(SKIP_REG), .SEQ_REG(SEQ_REG),
      .MAX_TRIES(MAX_TRIES), .CFG_VALUES(CFG_VALUES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_wdata(req_wdata),
      .sh_start(sh_start), .sh_tx(seq_tx), .sh_done(sh_done), .sh_rx(seq_rx),
      .cs_n(spi_cs_n), .adc_start(adc_start), .busy(busy), .done(done),
      .err(err), .rd_data(rd_data), .seq_value(seq_value)
   );

   adc_spi_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(wire_tx),
      .done(sh_done), .rx_byte(wire_rx), .sclk(spi_sclk), .mosi(spi_mosi),
      .miso(spi_miso)
   );

   assert_sclk_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> !spi_cs_n) else $error("SCLK high outside a frame");
endmodule

// File: tb/adc_regio_engine_tb.sv
module adc_regio_engine_tb;
   localparam logic [47:0] TB_CFG = 48'h66_55_44_33_22_11;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic [3:0] req_addr = 4'd0;
   logic [7:0] req_wdata = 8'd0;
   logic       busy, done, err, spi_cs_n, spi_sclk, spi_mosi, spi_miso, adc_start;
   logic [7:0] rd_data, seq_value;

   int n_chk = 0, n_err = 0;

   always #10 clk = ~clk;

   adc_regio_engine #(.CFG_VALUES(TB_CFG)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .err(err), .rd_data(rd_data), .seq_value(seq_value), .spi_cs_n(spi_cs_n),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .adc_start(adc_start)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // converter model: 16 registers, corrupts writes while fail_used < fail_budget
   logic [7:0] regs [16] = '{default: 8'h00};
   logic [7:0] shin = 8'h00, cmd = 8'h00, tx_load = 8'h00, fr_b0 = 8'h00, fr_b1 = 8'h00;
   logic [2:0] bitc = 3'd0;
   int         bytec = 0, fail_used = 0, fail_budget = 0;

   always @(negedge spi_cs_n or posedge spi_sclk) begin
      if (spi_cs_n || !spi_sclk) begin
         bitc = 3'd0; bytec = 0; fr_b0 = 8'h00; fr_b1 = 8'h00; cmd = 8'h00;
      end else begin
         shin = {shin[6:0], spi_mosi};
         bitc = bitc + 3'd1;
         if (bitc == 3'd0) begin
            if (bytec == 0) begin
               cmd = shin; fr_b0 = shin;
               if (shin == 8'hC0) for (int i = 0; i < 16; i++) regs[i] = 8'h00;
               if (shin[7:5] == 3'b010) tx_load = regs[shin[3:0]];
            end else if (bytec == 1) begin
               fr_b1 = shin;
               if (cmd[7:5] == 3'b011) begin
                  if (fail_used < fail_budget) begin
                     regs[cmd[3:0]] = shin ^ 8'h5A;
                     fail_used++;
                  end else regs[cmd[3:0]] = shin;
               end
            end
            bytec++;
         end
      end
   end
   assign spi_miso = (!spi_cs_n && bytec == 1 && cmd[7:5] == 3'b010) ? tx_load[~bitc] : 1'b0;

   // scoreboard
   logic [16:0] exp_fr [$];
   string       exp_tag [$];

   task automatic push_fr(input bit two, input logic [7:0] b0, input logic [7:0] b1, input string tag);
      exp_fr.push_back({two, b0, b1});
      exp_tag.push_back(tag);
   endtask
   task automatic push_rd(input logic [3:0] a, input string tag);
      push_fr(1'b1, {4'b0100, a}, 8'h00, tag);
   endtask
   task automatic push_wr(input logic [3:0] a, input logic [7:0] v, input int tries, input string tag);
      for (int k = 0; k < tries; k++) begin
         push_fr(1'b1, {4'b0110, a}, v, tag);
         push_rd(a, tag);
      end
   endtask

   always @(posedge spi_cs_n) begin
      if (bytec > 0) begin
         logic [16:0] got;
         got = {bytec == 2, fr_b0, fr_b1};
         if (exp_fr.size() == 0) chk(1'b0, "R3 unexpected frame", int'(got), 0);
         else begin
            logic [16:0] e;
            string t;
            e = exp_fr.pop_front();
            t = exp_tag.pop_front();
            chk(got == e, {t, " frame"}, int'(got), int'(e));
         end
      end
   end

   // R2 bit-level monitor
   int mosi_bad = 0;
   always @(spi_mosi) if (rst_n && spi_sclk) mosi_bad++;

   task automatic do_req(input logic [1:0] op, input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R10 busy after accept", busy, 1);
      while (!done) @(negedge clk);
      chk(!busy, "R10 busy low with done", busy, 0);
      chk(exp_fr.size() == 0, "R3 all frames seen", exp_fr.size(), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL R10 watchdog expired, expected done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !err, "R10 reset flags", {busy, done, err}, 0);
      chk(spi_cs_n && !spi_sclk, "R10 reset pins", {spi_cs_n, spi_sclk}, 2);
      chk(!adc_start, "R10 reset start", adc_start, 0);

      push_wr(4'd7, 8'hA5, 1, "R3");
      do_req(2'd1, 4'd7, 8'hA5);
      chk(rd_data == 8'hA5 && !err, "R3 write readback", rd_data, 8'hA5);

      push_rd(4'd7, "R1");
      do_req(2'd0, 4'd7, 8'h00);
      chk(rd_data == 8'hA5, "R1 read reg7", rd_data, 8'hA5);
      push_rd(4'd0, "R1");
      do_req(2'd0, 4'd0, 8'hFF);
      chk(rd_data == 8'h00, "R1 read reg0", rd_data, 8'h00);

      push_wr(4'd4, 8'h00, 1, "R9");
      do_req(2'd3, 4'd0, 8'h00);
      chk(adc_start == 1'b1, "R9 start after scan", adc_start, 1);

      push_fr(1'b0, 8'hC0, 8'h00, "R6");
      for (int i = 0; i < 6; i++)
         push_wr(4'((i >= 2) ? i + 1 : i), TB_CFG[8*i +: 8], 1, "R7");
      do_req(2'd2, 4'd0, 8'h00);
      chk(adc_start == 1'b0, "R6 start low after config", adc_start, 0);
      chk(seq_value == 8'h44, "R8 retained after config", seq_value, 8'h44);
      chk(!err, "R7 config no error", err, 0);

      push_wr(4'd4, 8'h44, 1, "R9");
      do_req(2'd3, 4'd0, 8'h00);
      chk(adc_start == 1'b1, "R9 start after scan restart", adc_start, 1);

      fail_budget = fail_used + 2;
      push_wr(4'd5, 8'h3C, 3, "R4");
      do_req(2'd1, 4'd5, 8'h3C);
      chk(rd_data == 8'h3C && !err, "R4 retried write", rd_data, 8'h3C);

      fail_budget = fail_used + 20;
      push_wr(4'd6, 8'h11, 15, "R5");
      do_req(2'd1, 4'd6, 8'h11);
      chk(err == 1'b1, "R5 error after 15 attempts", err, 1);
      fail_budget = fail_used;
      push_rd(4'd6, "R5");
      do_req(2'd0, 4'd6, 8'h00);
      chk(err == 1'b0, "R5 err cleared", err, 0);
      chk(rd_data == 8'h4B, "R5 corrupted value kept", rd_data, 8'h4B);

      fail_budget = fail_used + 20;
      push_wr(4'd4, 8'h44, 15, "R9");
      do_req(2'd3, 4'd0, 8'h00);
      chk(err && !adc_start, "R9 failed scan keeps start low", {err, adc_start}, 2);
      fail_budget = fail_used;

      push_wr(4'd4, 8'h9C, 1, "R8");
      do_req(2'd1, 4'd4, 8'h9C);
      chk(seq_value == 8'h9C, "R8 plain write updates retained", seq_value, 8'h9C);

      repeat (5) @(negedge clk);
      chk(mosi_bad == 0, "R2 mosi changed while sclk high", mosi_bad, 0);
      chk(!spi_sclk && spi_cs_n, "R2 idle pins", {spi_sclk, spi_cs_n}, 1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule